// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block turns a short packet held in a small byte buffer into line states for the two low-speed USB data wires. A single-cycle start request latches a byte count. The count covers the whole packet, sync byte included. The block then walks the buffer through a plain combinational read port: address in, byte back in the same cycle. It first presets the wires to the idle J level, and only after that turns the drivers on. It sends a generated sync byte and then the buffer bytes, least significant bit first. The bit stream is NRZI coded, and a stuffed bit follows every run of six ones. The packet closes with an end-of-packet sequence, after which the drivers are released.

Handshake packets are two bytes long: sync plus a PID. Longer packets carry data. When a data packet has been fully sent, the block copies the pending device address into its active address output. PID and CRC bytes are prepared by the caller in the buffer. Each bit lasts a fixed whole number of clocks, which the bit-rate tolerance allows.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `drv_en_o`, `line_p_o`, `line_n_o`, `busy_o`, `done_o` and `dev_addr_o` are all 0.
- R2: One clock after a start is accepted, the outputs show J (`line_n_o`=1, `line_p_o`=0) with `drv_en_o`=0. On the next clock `drv_en_o` rises together with the first packet bit.
- R3: The block sends the sync byte 0x80, then `len_i`-1 bytes read from buffer addresses 0, 1, 2, …, each byte least significant bit first. The NRZI coder starts from J, toggles the line for a 0 and holds it for a 1. Every line state lasts `CLKS_PER_BIT` clocks.
- R4: After six consecutive 1 bits, one extra toggle is inserted and the count of ones restarts. This holds across byte boundaries and also after the very last packet bit.
- R5: After the last bit, the block drives SE0 (both lines 0) for two bit periods and then J for one bit period, with `drv_en_o` high the whole time.
- R6: At release, `drv_en_o`, `line_p_o` and `line_n_o` go to 0, `busy_o` falls, and `done_o` is high for exactly one clock.
- R7: At release after a packet of 3 or more bytes, `dev_addr_o` takes the value of `new_addr_i`. After a 2-byte packet it keeps its value.
- R8: A `len_i` below 2 is treated as 2, and a `len_i` above `MAX_BYTES` is treated as `MAX_BYTES`.
- R9: `start_i` is ignored while a packet is in progress.
- R10: `busy_o` is high from the clock after a start is accepted until release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| len_i | input | LEN_W | Packet byte count including sync |
| rd_addr_o | output | BUF_AW | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, same cycle |
| new_addr_i | input | DEV_AW | Pending device address |
| dev_addr_o | output | DEV_AW | Active device address |
| line_p_o | output | 1 | D+ output level |
| line_n_o | output | 1 | D- output level |
| drv_en_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-clock pulse at bus release |

## Verification
The bench builds the block with `CLKS_PER_BIT`=3 and `MAX_BYTES`=12, so a full packet takes only a few hundred clocks. This short bit period lets the bench sweep every length from 2 to 12 against four byte patterns and compare the wires on every clock. The patterns are chosen to cover long runs of ones, stuffing that crosses byte boundaries, and a stuffed bit just before SE0. It also covers clamped lengths, a start pulse in mid-packet, and the handshake-versus-data rule for the address.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_TX,
    S_EOP0,
    S_EOPJ
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usb_ls_tx_tick.sv
module usb_ls_tx_tick #(
  parameter int CLKS_PER_BIT = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i || cnt_q == LAST) cnt_d = '0;
    else                          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usb_ls_tx_enc.sv
module usb_ls_tx_enc #(
  parameter int STUFF_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  input  logic bit_i,
  output logic stuff_due_o,
  output logic lvl_nxt_o
);
  localparam int RUN_W = $clog2(STUFF_LEN + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             lvl_q, lvl_d;
  logic             toggle;

  assign stuff_due_o = (run_q == RUN_W'(STUFF_LEN));
  assign toggle      = stuff_due_o || !bit_i;
  assign lvl_nxt_o   = step_i ? (lvl_q ^ toggle) : lvl_q;

  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    if (load_i) begin
      run_d = '0;
      lvl_d = 1'b1;
    end else if (step_i) begin
      lvl_d = lvl_nxt_o;
      run_d = toggle ? '0 : run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (load_i || step_i) begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end

  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(STUFF_LEN));

  a_r4_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && stuff_due_o) |=> (run_q == '0) && (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 33,
  parameter int MAX_BYTES    = 12,
  parameter int DEV_AW       = 7,
  parameter int STUFF_LEN    = 6,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1),
  localparam int BUF_AW      = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BUF_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic [DEV_AW-1:0] new_addr_i,
  output logic [DEV_AW-1:0] dev_addr_o,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              drv_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  tx_state_e         st_q, st_d;
  logic [7:0]        shift_q, shift_d;
  logic [2:0]        bidx_q, bidx_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [BUF_AW-1:0] raddr_q, raddr_d;
  logic              last_q, last_d;
  logic              hs_q, hs_d;
  logic              oe_q, oe_d, dp_q, dp_d, dm_q, dm_d;
  logic              pulse_q, pulse_d;
  logic [DEV_AW-1:0] addr_q, addr_d;

  logic [LEN_W-1:0]  len_eff;
  logic              tick, run_tick, stuff_due, lvl_nxt;
  logic              load, emit, consume, eop_go;

  assign len_eff  = (len_i < LEN_MIN) ? LEN_MIN : (len_i > LEN_MAX) ? LEN_MAX : len_i;
  assign run_tick = (st_q == S_TX) || (st_q == S_EOP0) || (st_q == S_EOPJ);
  assign load     = (st_q == S_IDLE) && start_i;
  assign emit     = (st_q == S_PRE) ||
                    ((st_q == S_TX) && tick && (stuff_due || !last_q));
  assign consume  = emit && !stuff_due;
  assign eop_go   = (st_q == S_TX) && tick && !stuff_due && last_q;

  usb_ls_tx_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_tick),
    .tick_o (tick)
  );

  usb_ls_tx_enc #(.STUFF_LEN(STUFF_LEN)) u_enc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .step_i      (emit),
    .bit_i       (shift_q[0]),
    .stuff_due_o (stuff_due),
    .lvl_nxt_o   (lvl_nxt)
  );

  always_comb begin
    st_d    = st_q;
    shift_d = shift_q;
    bidx_d  = bidx_q;
    left_d  = left_q;
    raddr_d = raddr_q;
    last_d  = last_q;
    hs_d    = hs_q;
    oe_d    = oe_q;
    dp_d    = dp_q;
    dm_d    = dm_q;
    pulse_d = 1'b0;
    addr_d  = addr_q;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = S_PRE;
        shift_d = SYNC_BYTE;
        bidx_d  = '0;
        left_d  = len_eff - LEN_W'(1);
        raddr_d = '0;
        last_d  = 1'b0;
        hs_d    = (len_eff == LEN_MIN);
        oe_d    = 1'b0;
        dp_d    = 1'b0;
        dm_d    = 1'b1;
      end
      S_PRE:  st_d = S_TX;
      S_TX:   if (eop_go) begin
        st_d   = S_EOP0;
        bidx_d = '0;
        dp_d   = 1'b0;
        dm_d   = 1'b0;
      end
      S_EOP0: if (tick) begin
        if (bidx_q == 3'd1) begin
          st_d = S_EOPJ;
          dp_d = 1'b0;
          dm_d = 1'b1;
        end else begin
          bidx_d = bidx_q + 3'd1;
        end
      end
      S_EOPJ: if (tick) begin
        st_d    = S_IDLE;
        oe_d    = 1'b0;
        dp_d    = 1'b0;
        dm_d    = 1'b0;
        pulse_d = 1'b1;
        if (!hs_q) addr_d = new_addr_i;
      end
      default: st_d = S_IDLE;
    endcase
    if (consume) begin
      shift_d = {1'b0, shift_q[7:1]};
      bidx_d  = bidx_q + 3'd1;
      if (bidx_q == 3'd7) begin
        if (left_q == '0) begin
          last_d = 1'b1;
        end else begin
          shift_d = rd_data_i;
          raddr_d = raddr_q + BUF_AW'(1);
          left_d  = left_q - LEN_W'(1);
        end
      end
    end
    if (emit) begin
      oe_d = 1'b1;
      dp_d = !lvl_nxt;
      dm_d = lvl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      shift_q <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      raddr_q <= '0;
      last_q  <= 1'b0;
      hs_q    <= 1'b0;
      oe_q    <= 1'b0;
      dp_q    <= 1'b0;
      dm_q    <= 1'b0;
      pulse_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q    <= st_d;
      shift_q <= shift_d;
      bidx_q  <= bidx_d;
      left_q  <= left_d;
      raddr_q <= raddr_d;
      last_q  <= last_d;
      hs_q    <= hs_d;
      oe_q    <= oe_d;
      dp_q    <= dp_d;
      dm_q    <= dm_d;
      pulse_q <= pulse_d;
      addr_q  <= addr_d;
    end
  end

  assign rd_addr_o  = raddr_q;
  assign dev_addr_o = addr_q;
  assign line_p_o   = dp_q;
  assign line_n_o   = dm_q;
  assign drv_en_o   = oe_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = pulse_q;

  a_r2_j_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(dm_q && !dp_q));

  a_r5_se0_only_in_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !dp_q && !dm_q) |-> (st_q == S_EOP0));

  a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (!oe_q && !dp_q && !dm_q && !busy_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  a_r7_addr_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> pulse_q);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && st_q != S_EOPJ) |=> busy_o);
endmodule

// File: tb/tb_usb_ls_tx.sv
module tb_usb_ls_tx;
  localparam int CPB = 3;
  localparam int MAXB = 12;

  logic       clk, rst_n, start_i;
  logic [3:0] len_i;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic [6:0] new_addr_i, dev_addr_o;
  logic       line_p_o, line_n_o, drv_en_o, busy_o, done_o;

  logic [7:0] mem [0:15];
  logic [1:0] exp_sym [0:255];
  int         nexp;
  int         checks, failures;
  logic [6:0] exp_addr;
  bit         finished;

  assign rd_data_i = mem[rd_addr_o];

  usb_ls_tx #(.CLKS_PER_BIT(CPB), .MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .new_addr_i(new_addr_i), .dev_addr_o(dev_addr_o),
    .line_p_o(line_p_o), .line_n_o(line_n_o), .drv_en_o(drv_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int idx, input int len);
    case (pat)
      0:       return 8'hFF;
      1:       return 8'h00;
      2:       return 8'hFC;
      default: return 8'((idx * 37 + len * 11 + 5) & 255);
    endcase
  endfunction

  task automatic build_expected(input int leff);
    logic       lvl;
    int         run;
    logic [7:0] b;
    nexp = 0;
    lvl  = 1'b1;
    run  = 0;
    for (int k = 0; k < leff; k++) begin
      b = (k == 0) ? 8'h80 : mem[k-1];
      for (int j = 0; j < 8; j++) begin
        if (!b[j]) begin lvl = ~lvl; run = 0; end
        else run++;
        exp_sym[nexp] = lvl ? 2'b01 : 2'b10; nexp++;
        if (run == 6) begin
          lvl = ~lvl; run = 0;
          exp_sym[nexp] = lvl ? 2'b01 : 2'b10; nexp++;
        end
      end
    end
    exp_sym[nexp] = 2'b00; nexp++;
    exp_sym[nexp] = 2'b00; nexp++;
    exp_sym[nexp] = 2'b01; nexp++;
  endtask

  task automatic run_packet(input int len_req, input int pat, input bit poke_start);
    int leff, bad_line, bad_eop, first_act, first_exp;
    leff = (len_req < 2) ? 2 : (len_req > MAXB) ? MAXB : len_req;
    for (int i = 0; i < 16; i++) mem[i] = pat_byte(pat, i, leff);
    build_expected(leff);
    @(negedge clk);
    len_i      = 4'(len_req);
    new_addr_i = 7'((len_req * 29 + pat * 7 + 3) & 127);
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(line_n_o && !line_p_o && !drv_en_o, "R2 J preset before enable",
          {drv_en_o, line_p_o, line_n_o}, 3'b001);
    check(busy_o, "R10 busy after start", busy_o, 1);
    @(negedge clk);
    check(drv_en_o, "R2 driver enable with first bit", drv_en_o, 1);
    bad_line = 0; bad_eop = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < nexp * CPB; i++) begin
      if (i == 5 && poke_start) begin
        start_i = 1'b1;
        len_i   = 4'd2;
      end
      if (i == 6) start_i = 1'b0;
      if ({line_p_o, line_n_o} != exp_sym[i / CPB] || !drv_en_o || !busy_o || done_o) begin
        if (bad_line + bad_eop == 0) begin
          first_act = {done_o, busy_o, drv_en_o, line_p_o, line_n_o};
          first_exp = {3'b011, exp_sym[i / CPB]};
        end
        if (i / CPB < nexp - 3) bad_line++;
        else bad_eop++;
      end
      @(negedge clk);
    end
    if (poke_start)
      check(bad_line == 0, "R9 start ignored mid-packet", first_act, first_exp);
    else
      check(bad_line == 0, "R3 R4 NRZI stuffed bits", first_act, first_exp);
    check(bad_eop == 0, "R5 SE0 SE0 J end", first_act, first_exp);
    check(done_o && !busy_o && !drv_en_o && !line_p_o && !line_n_o, "R6 release",
          {done_o, busy_o, drv_en_o, line_p_o, line_n_o}, 5'b10000);
    if (leff > 2) exp_addr = new_addr_i;
    check(dev_addr_o == exp_addr, (leff > 2) ? "R7 address commit" : "R7 address kept",
          dev_addr_o, exp_addr);
    if (len_req != leff)
      check(1'b1 && bad_line == 0, "R8 length clamp", len_req, leff);
    @(negedge clk);
    check(!done_o, "R6 done one clock", done_o, 0);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    exp_addr = '0;
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; new_addr_i = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!drv_en_o && !line_p_o && !line_n_o && !busy_o && !done_o && dev_addr_o == 0,
          "R1 reset state", {drv_en_o, line_p_o, line_n_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!drv_en_o && !busy_o, "R1 idle after reset", {drv_en_o, busy_o}, 0);
    for (int pat = 0; pat < 4; pat++)
      for (int len = 2; len <= MAXB; len++)
        run_packet(len, pat, 1'b0);
    run_packet(1, 3, 1'b0);
    run_packet(0, 0, 1'b0);
    run_packet(15, 0, 1'b0);
    run_packet(13, 2, 1'b0);
    run_packet(5, 3, 1'b1);
    run_packet(2, 0, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule